// File: doc/BRIEF.md
# Three-Mode Maskable Interrupt Sequencer

This block sits beside a processor core's instruction sequencer. It decides, at the sample point of an instruction's last machine cycle, whether an active-low maskable interrupt request is taken. Once a request is taken, it runs one of three response behaviours:

- **Fetch mode:** one or more opcode bytes taken from the data bus are handed to the core.
- **Fixed mode:** a restart to a constant address, with a program-counter push.
- **Table mode:** a 16-bit vector is read from a table whose address combines a high-byte input with a bus byte, followed by a program-counter push.

The block holds three pieces of state: the global enable flag, the per-source enable bit and the current response mode. The core updates them through single-cycle command strobes. A pending non-maskable interrupt always wins at a shared sample point. Taking a request clears the global enable, so the same source cannot re-enter until software re-enables it.

Top module: `irq_mode_seq`

## Requirements
- R1: After reset the global enable reads 0, the source enable reads 1 and the mode reads 0. No acknowledge, fetch, read or PC-load output is active.
- R2: A request is taken only when `sample_stb_i` is 1 and `irq_n_i` is 0 in the same cycle. The acknowledge `ack_o` is then high for exactly one cycle, in the following cycle. A low request without the strobe, or a high request with the strobe, does nothing.
- R3: A request is not taken while the global enable is 0 or the source enable is 0.
- R4: A request is not taken when `nmi_pend_i` is 1 at the sample point, and the global enable is then left unchanged.
- R5: The command strobes act as follows:
  - `ei_i` sets the global enable.
  - `di_i` clears the global enable.
  - `src_wr_i` loads the source enable from `src_val_i`.
  - `mode_wr_i` loads the mode from `mode_sel_i` for the values 0, 1 and 2. The value 3 is ignored.
- R6: Taking a request clears the global enable. The flag reads 0 from the acknowledge cycle on.
- R7: In mode 0, the bus byte present in the acknowledge cycle appears on `ifetch_byte_o` with `ifetch_vld_o` high one cycle later. Mode 0 never raises `push_req_o` or `pc_ld_o`.
- R8: In mode 0, if `more_i` is 1, the block fetches one further bus byte per cycle. It keeps doing so while `more_i` stays 1, including the cycle in which `more_i` drops. Each of these bytes is presented one cycle after it is captured.
- R9: In mode 1, `pc_ld_o` and `push_req_o` are high together one cycle after the acknowledge, with `pc_new_o` = 0x0038.
- R10: In mode 2:
  - The bus byte in the acknowledge cycle is the table's low address byte, and `vec_hi_i` is its high byte.
  - `rd_req_o` is high in the next two cycles, with `rd_addr_o` at the table address and then at the table address plus one, wrapping at 16 bits.
  - The byte on `rd_data_i` in the cycle after each request is the low and then the high byte of the new PC.
  - `pc_ld_o` and `push_req_o` come four cycles after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n_i | input | 1 | Maskable interrupt request, active low |
| sample_stb_i | input | 1 | Last-machine-cycle sample point |
| nmi_pend_i | input | 1 | Non-maskable interrupt pending |
| ei_i | input | 1 | Enable-interrupts command |
| di_i | input | 1 | Disable-interrupts command |
| src_wr_i | input | 1 | Source enable write strobe |
| src_val_i | input | 1 | Source enable write value |
| mode_wr_i | input | 1 | Set-mode command |
| mode_sel_i | input | 2 | Requested mode |
| bus_data_i | input | 8 | Data bus byte |
| more_i | input | 1 | Mode 0: further opcode bytes follow |
| vec_hi_i | input | 8 | Mode 2 table high address byte |
| rd_data_i | input | 8 | Table read data, one cycle after request |
| ack_o | output | 1 | Acknowledge strobe |
| ifetch_vld_o | output | 1 | Fetched opcode byte valid |
| ifetch_byte_o | output | 8 | Fetched opcode byte |
| push_req_o | output | 1 | Push current PC |
| pc_ld_o | output | 1 | Load PC from pc_new_o |
| pc_new_o | output | 16 | New PC |
| rd_req_o | output | 1 | Table read request |
| rd_addr_o | output | 16 | Table read address |
| gie_o | output | 1 | Global enable flag |
| src_en_o | output | 1 | Source enable bit |
| mode_o | output | 2 | Current response mode |

## Verification
Counting from the sample cycle c, the timing of each result is:

| Result | Cycle |
|---|---|
| Acknowledge | c+1 |
| Mode 0 opcode bytes | c+2, c+3, … one per cycle |
| Mode 1 PC load | c+2 |
| Mode 2 table reads | c+2 and c+3 |
| Mode 2 PC load | c+5 |

The driver stamps each expected item with its absolute cycle number. The monitor samples the outputs at the falling edge and compares both the value and the cycle of every event it pops. An event that appears while the queue is empty counts as a failure, which is how masked, blocked and unstrobed requests are shown to have no effect.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  localparam logic [1:0] MODE_FETCH = 2'd0;
  localparam logic [1:0] MODE_FIXED = 2'd1;
  localparam logic [1:0] MODE_TABLE = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_FETCH_MORE,
    ST_TBL_LO,
    ST_TBL_HI,
    ST_TBL_END
  } seq_state_t;

  function automatic logic [ADDR_W-1:0] tbl_addr(input logic [BYTE_W-1:0] hi,
                                                 input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] tbl_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic mode_legal(input logic [1:0] m);
    return m != 2'd3;
  endfunction
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ei_i,
  input  logic       di_i,
  input  logic       src_wr_i,
  input  logic       src_val_i,
  input  logic       mode_wr_i,
  input  logic [1:0] mode_sel_i,
  input  logic       accept_i,
  output logic       gie_o,
  output logic       src_en_o,
  output logic [1:0] mode_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_o    <= 1'b0;
      src_en_o <= 1'b1;
      mode_o   <= MODE_FETCH;
    end else begin
      if (accept_i || di_i) gie_o <= 1'b0;
      else if (ei_i)        gie_o <= 1'b1;
      if (src_wr_i) src_en_o <= src_val_i;
      if (mode_wr_i && mode_legal(mode_sel_i)) mode_o <= mode_sel_i;
    end
  end

  // R6
  accept_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !gie_o);
  // R5
  illegal_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_i && mode_sel_i == 2'd3) |=> $stable(mode_o));
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic idle_i,
  input  logic sample_stb_i,
  input  logic irq_n_i,
  input  logic nmi_pend_i,
  input  logic gie_i,
  input  logic src_en_i,
  output logic accept_o
);
  logic unmasked;
  logic sampled_low;

  assign unmasked    = gie_i && src_en_i;
  assign sampled_low = sample_stb_i && !irq_n_i;
  assign accept_o    = idle_i && sampled_low && unmasked && !nmi_pend_i;
endmodule

// File: rtl/irq_resp_fsm.sv
module irq_resp_fsm
  import irq_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [1:0]        mode_i,
  input  logic [BYTE_W-1:0] bus_data_i,
  input  logic              more_i,
  input  logic [BYTE_W-1:0] vec_hi_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              idle_o,
  output logic              ack_o,
  output logic              ifetch_vld_o,
  output logic [BYTE_W-1:0] ifetch_byte_o,
  output logic              push_req_o,
  output logic              pc_ld_o,
  output logic [ADDR_W-1:0] pc_new_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  seq_state_t        state;
  logic [1:0]        resp_mode;
  logic [BYTE_W-1:0] vec_lo;
  logic [BYTE_W-1:0] pc_lo;
  logic [ADDR_W-1:0] tbl_base;

  assign tbl_base  = tbl_addr(vec_hi_i, vec_lo);
  assign idle_o    = state == ST_IDLE;
  assign ack_o     = state == ST_ACK;
  assign rd_req_o  = (state == ST_TBL_LO) || (state == ST_TBL_HI);
  assign rd_addr_o = (state == ST_TBL_HI) ? tbl_next(tbl_base) : tbl_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      resp_mode     <= MODE_FETCH;
      vec_lo        <= '0;
      pc_lo         <= '0;
      ifetch_vld_o  <= 1'b0;
      ifetch_byte_o <= '0;
      push_req_o    <= 1'b0;
      pc_ld_o       <= 1'b0;
      pc_new_o      <= '0;
    end else begin
      ifetch_vld_o <= 1'b0;
      push_req_o   <= 1'b0;
      pc_ld_o      <= 1'b0;
      case (state)
        ST_IDLE: if (accept_i) begin
          resp_mode <= mode_i;
          state     <= ST_ACK;
        end
        ST_ACK: begin
          case (resp_mode)
            MODE_FETCH: begin
              ifetch_byte_o <= bus_data_i;
              ifetch_vld_o  <= 1'b1;
              state         <= more_i ? ST_FETCH_MORE : ST_IDLE;
            end
            MODE_FIXED: begin
              pc_new_o   <= RESTART_ADDR;
              pc_ld_o    <= 1'b1;
              push_req_o <= 1'b1;
              state      <= ST_IDLE;
            end
            default: begin
              vec_lo <= bus_data_i;
              state  <= ST_TBL_LO;
            end
          endcase
        end
        ST_FETCH_MORE: begin
          ifetch_byte_o <= bus_data_i;
          ifetch_vld_o  <= 1'b1;
          if (!more_i) state <= ST_IDLE;
        end
        ST_TBL_LO: state <= ST_TBL_HI;
        ST_TBL_HI: begin
          pc_lo <= rd_data_i;
          state <= ST_TBL_END;
        end
        ST_TBL_END: begin
          pc_new_o   <= {rd_data_i, pc_lo};
          pc_ld_o    <= 1'b1;
          push_req_o <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  pc_ld_with_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld_o |-> push_req_o);
  // R7
  fetch_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch_vld_o |-> !push_req_o);
  // R10
  tbl_second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_req_o) && rd_req_o) |-> rd_addr_o == $past(rd_addr_o) + 16'd1);
  // R2
  ack_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_o, pc_ld_o, rd_req_o}));
endmodule

// File: rtl/irq_mode_seq.sv
module irq_mode_seq
  import irq_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n_i,
  input  logic              sample_stb_i,
  input  logic              nmi_pend_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              src_wr_i,
  input  logic              src_val_i,
  input  logic              mode_wr_i,
  input  logic [1:0]        mode_sel_i,
  input  logic [BYTE_W-1:0] bus_data_i,
  input  logic              more_i,
  input  logic [BYTE_W-1:0] vec_hi_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              ack_o,
  output logic              ifetch_vld_o,
  output logic [BYTE_W-1:0] ifetch_byte_o,
  output logic              push_req_o,
  output logic              pc_ld_o,
  output logic [ADDR_W-1:0] pc_new_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              gie_o,
  output logic              src_en_o,
  output logic [1:0]        mode_o
);
  logic accept_evt;
  logic seq_idle;

  irq_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ei_i(ei_i), .di_i(di_i),
    .src_wr_i(src_wr_i), .src_val_i(src_val_i),
    .mode_wr_i(mode_wr_i), .mode_sel_i(mode_sel_i),
    .accept_i(accept_evt), .gie_o(gie_o), .src_en_o(src_en_o), .mode_o(mode_o)
  );

  irq_gate u_gate (
    .idle_i(seq_idle), .sample_stb_i(sample_stb_i), .irq_n_i(irq_n_i),
    .nmi_pend_i(nmi_pend_i), .gie_i(gie_o), .src_en_i(src_en_o),
    .accept_o(accept_evt)
  );

  irq_resp_fsm #(.RESTART_ADDR(RESTART_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_evt), .mode_i(mode_o),
    .bus_data_i(bus_data_i), .more_i(more_i), .vec_hi_i(vec_hi_i),
    .rd_data_i(rd_data_i), .idle_o(seq_idle), .ack_o(ack_o),
    .ifetch_vld_o(ifetch_vld_o), .ifetch_byte_o(ifetch_byte_o),
    .push_req_o(push_req_o), .pc_ld_o(pc_ld_o), .pc_new_o(pc_new_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o)
  );

  // R2 R3 R4
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(sample_stb_i && !irq_n_i && gie_o && src_en_o && !nmi_pend_i));
  // R6
  ack_gie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !gie_o);
  // R4
  nmi_keeps_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb_i && nmi_pend_i && gie_o && !di_i) |=> gie_o);
endmodule

// File: tb/irq_mode_seq_tb.sv
`timescale 1ns/1ps
module irq_mode_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_n = 1'b1, stb = 1'b0, nmi = 1'b0;
  logic ei = 1'b0, di = 1'b0, src_wr = 1'b0, src_val = 1'b0;
  logic mode_wr = 1'b0, more = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [7:0] bus = 8'h00, vec_hi = 8'h00, rd_data = 8'h00;
  logic ack, ifv, push, pcld, rdreq, gie, srcen;
  logic [7:0] ifb;
  logic [15:0] pcnew, rdaddr;
  logic [1:0] mode;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  typedef struct {
    int cyc;
    int kind;
    int val;
    string req;
  } ev_t;
  ev_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .sample_stb_i(stb),
    .nmi_pend_i(nmi), .ei_i(ei), .di_i(di), .src_wr_i(src_wr),
    .src_val_i(src_val), .mode_wr_i(mode_wr), .mode_sel_i(mode_sel),
    .bus_data_i(bus), .more_i(more), .vec_hi_i(vec_hi), .rd_data_i(rd_data),
    .ack_o(ack), .ifetch_vld_o(ifv), .ifetch_byte_o(ifb), .push_req_o(push),
    .pc_ld_o(pcld), .pc_new_o(pcnew), .rd_req_o(rdreq), .rd_addr_o(rdaddr),
    .gie_o(gie), .src_en_o(srcen), .mode_o(mode)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  // table memory model: one cycle of read latency
  always @(negedge clk) begin
    logic req_s;
    logic [15:0] addr_s;
    req_s = rdreq;
    addr_s = rdaddr;
    @(posedge clk);
    #1 rd_data = req_s ? mem(addr_s) : 8'h00;
  end

  task automatic check(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  task automatic expect_ev(input int c, input int k, input int v, input string req);
    ev_t e;
    e.cyc = c; e.kind = k; e.val = v; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic got_ev(input int k, input int v);
    ev_t e;
    if (exp_q.size() == 0) begin
      checks++; failures++;
      $display("FAIL %s unexpected event kind=%0d actual=%0h expected=none", cur_req, k, v);
    end else begin
      e = exp_q.pop_front();
      check(e.req, k, e.kind, "event kind");
      check(e.req, v, e.val, "event value");
      check(e.req, cyc, e.cyc, "event cycle");
    end
  endtask

  // monitor: 1 ack, 2 fetch byte, 3 read address, 4 {push, pc}
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack) got_ev(1, 0);
      if (ifv) got_ev(2, {23'd0, push, ifb});
      if (rdreq) got_ev(3, {16'd0, rdaddr});
      if (pcld) got_ev(4, {15'd0, push, pcnew});
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_ei();
    ei = 1'b1; step(); ei = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_sel = m; mode_wr = 1'b1; step(); mode_wr = 1'b0;
  endtask

  task automatic set_src(input logic v);
    src_val = v; src_wr = 1'b1; step(); src_wr = 1'b0;
  endtask

  // sample cycle; returns its cycle number
  task automatic sample(input logic lvl, input logic strobe, input logic [7:0] b,
                        input logic m, output int c);
    irq_n = lvl; stb = strobe; bus = b; more = m; c = cyc;
    step();
    stb = 1'b0; irq_n = 1'b1;
  endtask

  task automatic drain(input string req);
    repeat (8) step();
    check(req, exp_q.size(), 0, "pending expected events");
    more = 1'b0;
  endtask

  int c;

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1", gie, 0, "gie after reset");
    check("R1", srcen, 1, "src_en after reset");
    check("R1", mode, 0, "mode after reset");
    check("R1", {ack, ifv, pcld, rdreq, push}, 0, "outputs after reset");

    // R3 masked by global enable (cleared at reset)
    cur_req = "R3";
    sample(1'b0, 1'b1, 8'h11, 1'b0, c);
    drain("R3");
    // R5 ei sets gie
    pulse_ei();
    check("R5", gie, 1, "gie after ei");
    // R3 masked by source enable
    set_src(1'b0);
    check("R5", srcen, 0, "src_en write");
    sample(1'b0, 1'b1, 8'h11, 1'b0, c);
    drain("R3");
    check("R3", gie, 1, "gie kept when source masked");
    set_src(1'b1);

    // R2 no strobe, or high request
    cur_req = "R2";
    sample(1'b0, 1'b0, 8'h11, 1'b0, c);
    sample(1'b1, 1'b1, 8'h11, 1'b0, c);
    drain("R2");
    check("R2", gie, 1, "gie kept without acceptance");

    // R4 NMI priority
    cur_req = "R4";
    nmi = 1'b1;
    sample(1'b0, 1'b1, 8'h11, 1'b0, c);
    nmi = 1'b0;
    drain("R4");
    check("R4", gie, 1, "gie kept under nmi");

    // R7 mode 0 single byte
    cur_req = "R7";
    sample(1'b0, 1'b1, 8'hFF, 1'b0, c);
    expect_ev(c + 1, 1, 0, "R2");
    expect_ev(c + 2, 2, 32'h0FF, "R7");
    check("R6", gie, 0, "gie cleared on acceptance");
    drain("R7");

    // R8 mode 0 multibyte
    cur_req = "R8";
    pulse_ei();
    sample(1'b0, 1'b1, 8'hCB, 1'b1, c);
    expect_ev(c + 1, 1, 0, "R8");
    expect_ev(c + 2, 2, 32'h0CB, "R8");
    expect_ev(c + 3, 2, 32'h012, "R8");
    expect_ev(c + 4, 2, 32'h034, "R8");
    step(); bus = 8'h12; more = 1'b1;
    step(); bus = 8'h34; more = 1'b0;
    drain("R8");

    // R5 illegal mode ignored, R9 mode 1
    cur_req = "R9";
    set_mode(2'd1);
    check("R5", mode, 1, "mode write 1");
    set_mode(2'd3);
    check("R5", mode, 1, "mode write 3 ignored");
    pulse_ei();
    sample(1'b0, 1'b1, 8'h00, 1'b0, c);
    expect_ev(c + 1, 1, 0, "R9");
    expect_ev(c + 2, 4, 32'h10038, "R9");
    drain("R9");

    // R10 mode 2
    cur_req = "R10";
    set_mode(2'd2);
    pulse_ei();
    vec_hi = 8'h12;
    sample(1'b0, 1'b1, 8'h34, 1'b0, c);
    expect_ev(c + 1, 1, 0, "R10");
    expect_ev(c + 2, 3, 32'h1234, "R10");
    expect_ev(c + 3, 3, 32'h1235, "R10");
    expect_ev(c + 5, 4, {15'd0, 1'b1, mem(16'h1235), mem(16'h1234)}, "R10");
    drain("R10");

    // R10 wrap at 16 bits
    pulse_ei();
    vec_hi = 8'hFF;
    sample(1'b0, 1'b1, 8'hFF, 1'b0, c);
    expect_ev(c + 1, 1, 0, "R10");
    expect_ev(c + 2, 3, 32'hFFFF, "R10");
    expect_ev(c + 3, 3, 32'h0000, "R10");
    expect_ev(c + 5, 4, {15'd0, 1'b1, mem(16'h0000), mem(16'hFFFF)}, "R10");
    drain("R10");

    // R5 di clears gie
    pulse_ei();
    di = 1'b1; step(); di = 1'b0;
    check("R5", gie, 0, "gie after di");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule